// File: doc/BRIEF.md
# Programmable 16-bit Down-Counter/Timer

This block is a 16-bit down-counter reached through a small byte-wide register port. Software writes a start value as two bytes, then uses a command/status byte to open the gate, fire a trigger, freeze the count for read-back and clear the interrupt-pending flag. A mode byte picks the output waveform (single-cycle pulse, one-shot level or square wave) and chooses whether the count, trigger and gate come from internal sources or from external pins. It also chooses whether the output pin is driven, whether the counter reloads by itself at terminal count, and whether a new trigger restarts a running count.

The controller is a two-state machine. In IDLE the counter waits. The transition IDLE to RUN (start) is taken on a trigger, which loads the reload value. The transition RUN to RUN (restart) is taken on a trigger when retrigger is enabled. RUN to RUN (wrap) happens at terminal count in continuous mode. RUN to IDLE (expire) happens at terminal count otherwise. RUN to IDLE (abort) happens when the master enable drops. The internal count source is a clock-enable tick from a prescaler outside the block.

Top module: `ctmr_unit`

## Requirements
- R1: After reset the status byte (address 0), the live count (addresses 4 high byte, 5 low byte), `ctr_out_o` and `irq_o` are all zero.
- R2: The reload value is written as a low byte (address 2) and a high byte (address 3). Writing the command byte (address 0) with bit 2 set while idle loads the reload value into the count and sets the counting flag (status bit 0).
- R3: The count drops by one per count event only while the gate is open. The gate is open when command bit 1 is set and, if mode bit 5 is set, `ext_gate_i` is high. Otherwise the count holds.
- R4: A count event at a count of 1 is terminal count. It sets interrupt-pending (status bit 5) and `irq_o`. Without continuous mode the counter returns to idle, which clears status bit 0. Writing the command byte with bit 4 set clears interrupt-pending.
- R5: With continuous mode (mode bit 1... see R7 for duty; continuous is mode bit 2) terminal count reloads the reload value and counting goes on.
- R6: Writing the command byte with bit 3 set freezes the count into a snapshot and sets status bit 3. While frozen, addresses 4 and 5 return the snapshot. A read of address 5 releases the freeze, and later reads return the live count.
- R7: Mode bits [1:0] pick the output duty. 0 gives a one-cycle pulse after each terminal count. 1 gives a one-shot output that is high while counting. 2 gives a square wave that starts low and toggles at each terminal count. `ctr_out_o` follows the internal output only when mode bit 6 is set, and is 0 otherwise.
- R8: With mode bit 4 set, a rising edge on `ext_trig_i` acts as a trigger. With mode bit 3 set, only rising edges on `ext_cnt_i` are count events and `tick_i` is ignored.
- R9: A trigger while counting reloads the count only when mode bit 7 (retrigger) is set. Without it the trigger leaves the count unchanged.
- R10: While `ctr_en_i` is low, the gate bit, interrupt-pending and the freeze are cleared, and the counter returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_en_i | input | 1 | Master enable for this counter |
| tick_i | input | 1 | Internal count event (prescaled clock enable) |
| ext_cnt_i | input | 1 | External count pin, counted on rising edges |
| ext_trig_i | input | 1 | External trigger pin, rising edge |
| ext_gate_i | input | 1 | External gate pin, level |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effect on address 5) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ctr_out_o | output | 1 | Counter output waveform |
| irq_o | output | 1 | Interrupt-pending |

## Verification
The bench goes after the points where a counter is easy to get subtly wrong. The first is the terminal count at the step from 1: an off-by-one design would raise interrupt-pending a tick early or late, or would run a 65536-tick cycle. The second is a trigger that arrives while the counter is running without retrigger enabled: a careless design reloads anyway and the count jumps back. The third is the freeze: it must return the frozen value until the low byte is read and then return the live count; a design that releases the freeze on the high-byte read, or never releases it, gives stale or torn values. The bench also checks the square wave and the gating. It confirms that the square-wave phase actually flips at each wrap, that the external count pin fully replaces the internal tick, and that an external gate held low stops the count even while the gate bit is set.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam logic [2:0] ADR_CMD    = 3'd0;
    localparam logic [2:0] ADR_MODE   = 3'd1;
    localparam logic [2:0] ADR_RLD_LO = 3'd2;
    localparam logic [2:0] ADR_RLD_HI = 3'd3;
    localparam logic [2:0] ADR_CNT_HI = 3'd4;
    localparam logic [2:0] ADR_CNT_LO = 3'd5;

    // command byte bit positions
    localparam int CMD_GATE = 1;
    localparam int CMD_TRIG = 2;
    localparam int CMD_FRZ  = 3;
    localparam int CMD_CLIP = 4;

    typedef enum logic [1:0] {
        DUTY_PULSE   = 2'd0,
        DUTY_ONESHOT = 2'd1,
        DUTY_SQUARE  = 2'd2,
        DUTY_RSVD    = 2'd3
    } duty_e;

    typedef struct packed {
        logic  retrig;
        logic  ext_out;
        logic  ext_gate;
        logic  ext_trig;
        logic  ext_cnt;
        logic  cont;
        duty_e duty;
    } mode_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } ctr_state_e;

endpackage

// File: rtl/ctmr_edge.sv
module ctmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    assign rise_o = pin_i & ~prev_q;
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  mode_t         mode_i,
    input  logic [CW-1:0] reload_i,
    input  logic          trig_i,
    input  logic          tick_i,
    input  logic          gate_i,
    output logic [CW-1:0] count_o,
    output logic          running_o,
    output logic          tc_o,
    output logic          out_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    ctr_state_e    state_q, state_d;
    logic [CW-1:0] count_q;
    logic          out_q;
    logic          load, step, tc;

    assign load = en_i && trig_i && (state_q == S_IDLE || mode_i.retrig);
    assign step = en_i && (state_q == S_RUN) && gate_i && tick_i && !load;
    assign tc   = step && (count_q == ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (load) state_d = S_RUN;
            S_RUN: begin
                if (!en_i)                   state_d = S_IDLE;
                else if (tc && !mode_i.cont) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count_q <= '0;
        else if (load) count_q <= reload_i;
        else if (step) count_q <= tc ? (mode_i.cont ? reload_i : '0) : count_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_q <= 1'b0;
        else if (!en_i)    out_q <= 1'b0;
        else if (load)     out_q <= (mode_i.duty == DUTY_ONESHOT);
        else begin
            unique case (mode_i.duty)
                DUTY_ONESHOT: out_q <= (state_d == S_RUN);
                DUTY_SQUARE:  if (tc) out_q <= ~out_q;
                default:      out_q <= tc;
            endcase
        end
    end

    assign count_o   = count_q;
    assign running_o = (state_q == S_RUN);
    assign tc_o      = tc;
    assign out_o     = out_q;

    p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && trig_i && state_q == S_IDLE) |=> (state_q == S_RUN && count_q == $past(reload_i)));
    p_gate_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !gate_i && !trig_i) |=> $stable(count_q));
    p_wrap_reloads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode_i.cont) |=> (state_q == S_RUN && count_q == $past(reload_i)));
    p_square_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && en_i && mode_i.duty == DUTY_SQUARE) |=> (out_q != $past(out_q)));
    p_no_retrig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && trig_i && !mode_i.retrig && !gate_i) |=> $stable(count_q));
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [2:0]    addr_i,
    input  logic [7:0]    wdata_i,
    input  logic [CW-1:0] count_i,
    input  logic          running_i,
    input  logic          tc_i,
    output logic [7:0]    rdata_o,
    output mode_t         mode_o,
    output logic [CW-1:0] reload_o,
    output logic          gate_o,
    output logic          trig_o,
    output logic          ip_o
);
    logic [7:0]    mode_q, rld_lo_q, rld_hi_q;
    logic          gcb_q, ip_q, frz_q;
    logic [CW-1:0] snap_q, view;
    logic          cmd_wr, frz_wr, rel;

    assign cmd_wr = we_i && addr_i == ADR_CMD;
    assign frz_wr = cmd_wr && wdata_i[CMD_FRZ];
    assign rel    = re_i && addr_i == ADR_CNT_LO;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0; rld_lo_q <= '0; rld_hi_q <= '0;
        end else if (we_i) begin
            if (addr_i == ADR_MODE)   mode_q   <= wdata_i;
            if (addr_i == ADR_RLD_LO) rld_lo_q <= wdata_i;
            if (addr_i == ADR_RLD_HI) rld_hi_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcb_q <= 1'b0; ip_q <= 1'b0; frz_q <= 1'b0; snap_q <= '0;
        end else if (!en_i) begin
            gcb_q <= 1'b0; ip_q <= 1'b0; frz_q <= 1'b0;
        end else begin
            if (cmd_wr) gcb_q <= wdata_i[CMD_GATE];
            if (tc_i)                             ip_q <= 1'b1;
            else if (cmd_wr && wdata_i[CMD_CLIP]) ip_q <= 1'b0;
            if (frz_wr) begin
                snap_q <= count_i;
                frz_q  <= 1'b1;
            end else if (rel) begin
                frz_q  <= 1'b0;
            end
        end
    end

    assign view = frz_q ? snap_q : count_i;

    always_comb begin
        unique case (addr_i)
            ADR_CMD:    rdata_o = {2'b00, ip_q, 1'b0, frz_q, 1'b0, gcb_q, running_i};
            ADR_MODE:   rdata_o = mode_q;
            ADR_RLD_LO: rdata_o = rld_lo_q;
            ADR_RLD_HI: rdata_o = rld_hi_q;
            ADR_CNT_HI: rdata_o = view[CW-1:8];
            ADR_CNT_LO: rdata_o = view[7:0];
            default:    rdata_o = 8'h00;
        endcase
    end

    assign mode_o   = mode_t'(mode_q);
    assign reload_o = {rld_hi_q, rld_lo_q};
    assign gate_o   = gcb_q;
    assign trig_o   = cmd_wr && wdata_i[CMD_TRIG];
    assign ip_o     = ip_q;

    p_tc_sets_ip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i && en_i) |=> ip_q);
    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!gcb_q && !ip_q && !frz_q));
    p_snap_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && en_i && !rel && !frz_wr) |=> ($stable(snap_q) && frz_q));
endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
    import ctmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctr_en_i,
    input  logic       tick_i,
    input  logic       ext_cnt_i,
    input  logic       ext_trig_i,
    input  logic       ext_gate_i,
    input  logic       reg_we_i,
    input  logic       reg_re_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       ctr_out_o,
    output logic       irq_o
);
    localparam int NEDGE = 2;

    mode_t         mode;
    logic [CW-1:0] reload, count;
    logic          gcb, trig_sw, ip, running, tc, out_int;
    logic [NEDGE-1:0] pins, rises;
    logic          gate_ok, trig, tick;

    assign pins = {ext_trig_i, ext_cnt_i};

    for (genvar i = 0; i < NEDGE; i++) begin : g_edge
        ctmr_edge u_edge (.clk(clk), .rst_n(rst_n), .pin_i(pins[i]), .rise_o(rises[i]));
    end

    assign gate_ok = gcb && (!mode.ext_gate || ext_gate_i);
    assign trig    = trig_sw || (mode.ext_trig && rises[1]);
    assign tick    = mode.ext_cnt ? rises[0] : tick_i;

    ctmr_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .en_i(ctr_en_i),
        .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .count_i(count), .running_i(running), .tc_i(tc),
        .rdata_o(reg_rdata_o), .mode_o(mode), .reload_o(reload),
        .gate_o(gcb), .trig_o(trig_sw), .ip_o(ip)
    );

    ctmr_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .en_i(ctr_en_i), .mode_i(mode),
        .reload_i(reload), .trig_i(trig), .tick_i(tick), .gate_i(gate_ok),
        .count_o(count), .running_o(running), .tc_o(tc), .out_o(out_int)
    );

    assign ctr_out_o = mode.ext_out & out_int;
    assign irq_o     = ip;
endmodule

// File: tb/ctmr_unit_bench.sv
module ctmr_unit_bench;
    logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, tick = 1'b0;
    logic ecnt = 1'b0, etrig = 1'b0, egate = 1'b0;
    logic we = 1'b0, re = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic cout, irq;
    int checks = 0, failures = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    ctmr_unit u_ctmr_unit (
        .clk(clk), .rst_n(rst_n), .ctr_en_i(en), .tick_i(tick),
        .ext_cnt_i(ecnt), .ext_trig_i(etrig), .ext_gate_i(egate),
        .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .ctr_out_o(cout), .irq_o(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); re = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pin_pulse(input bit is_trig);
        @(negedge clk); if (is_trig) etrig = 1'b1; else ecnt = 1'b1;
        @(negedge clk); etrig = 1'b0; ecnt = 1'b0;
    endtask

    task automatic t_reset();
        rd(3'd0, v); check("R1 status", v, 8'h00);
        rd(3'd5, v); check("R1 count lo", v, 8'h00);
        rd(3'd4, v); check("R1 count hi", v, 8'h00);
        check("R1 out", cout, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_load();
        wr(3'd2, 8'h05); wr(3'd3, 8'h00);
        wr(3'd1, 8'h41);
        wr(3'd0, 8'h06);
        rd(3'd5, v); check("R2 loaded count", v, 8'h05);
        rd(3'd0, v); check("R2 counting flag", v, 8'h03);
        check("R7 one-shot high while counting", cout, 1);
    endtask

    task automatic t_gate();
        wr(3'd0, 8'h04);
        ticks(3);
        rd(3'd5, v); check("R3 gate closed holds", v, 8'h05);
        wr(3'd0, 8'h02);
        ticks(3);
        rd(3'd5, v); check("R3 counts with gate", v, 8'h02);
        ticks(2);
        rd(3'd0, v); check("R4 terminal count status", v, 8'h22);
        check("R4 irq at terminal", irq, 1);
        check("R7 one-shot low after expire", cout, 0);
        wr(3'd0, 8'h12);
        rd(3'd0, v); check("R4 pending cleared", v, 8'h02);
    endtask

    task automatic t_cont_square();
        wr(3'd2, 8'h03);
        wr(3'd1, 8'h46);
        wr(3'd0, 8'h06);
        check("R7 square starts low", cout, 0);
        ticks(3);
        check("R7 square toggled", cout, 1);
        rd(3'd0, v); check("R5 continuous keeps running", v, 8'h23);
        rd(3'd5, v); check("R5 reloaded at wrap", v, 8'h03);
        ticks(3);
        check("R7 square toggled back", cout, 0);
        wr(3'd0, 8'h12);
    endtask

    task automatic t_pulse();
        wr(3'd1, 8'h44);
        ticks(2);
        ticks(1);
        check("R7 pulse high after terminal", cout, 1);
        @(negedge clk);
        check("R7 pulse one cycle", cout, 0);
        wr(3'd1, 8'h05);
        @(negedge clk);
        check("R7 output pin disabled", cout, 0);
        wr(3'd0, 8'h12);
    endtask

    task automatic t_freeze();
        wr(3'd2, 8'h23); wr(3'd3, 8'h01);
        wr(3'd1, 8'h80); wr(3'd0, 8'h06);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h0A);
        ticks(5);
        rd(3'd0, v); check("R6 frozen flag", v, 8'h0B);
        rd(3'd4, v); check("R6 frozen hi", v, 8'h01);
        rd(3'd5, v); check("R6 frozen lo", v, 8'h23);
        rd(3'd5, v); check("R6 live lo after release", v, 8'h1E);
        rd(3'd0, v); check("R6 flag released", v, 8'h03);
    endtask

    task automatic t_retrig();
        wr(3'd2, 8'h40); wr(3'd3, 8'h00);
        wr(3'd0, 8'h06);
        rd(3'd5, v); check("R9 trigger ignored while counting", v, 8'h1E);
        wr(3'd1, 8'h80); wr(3'd0, 8'h06);
        rd(3'd5, v); check("R9 retrigger reloads lo", v, 8'h40);
        rd(3'd4, v); check("R9 retrigger reloads hi", v, 8'h00);
    endtask

    task automatic t_disable();
        wr(3'd0, 8'h0A);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        rd(3'd0, v); check("R10 disable clears status", v, 8'h00);
    endtask

    task automatic t_ext();
        wr(3'd1, 8'h18); wr(3'd0, 8'h02);
        pin_pulse(1'b1);
        rd(3'd0, v); check("R8 external trigger starts", v, 8'h03);
        ticks(3);
        rd(3'd5, v); check("R8 internal tick ignored", v, 8'h40);
        for (int i = 0; i < 3; i++) pin_pulse(1'b0);
        rd(3'd5, v); check("R8 external count edges", v, 8'h3D);
        wr(3'd1, 8'h38);
        for (int i = 0; i < 2; i++) pin_pulse(1'b0);
        rd(3'd5, v); check("R3 external gate low holds", v, 8'h3D);
        egate = 1'b1;
        pin_pulse(1'b0);
        rd(3'd5, v); check("R3 external gate high counts", v, 8'h3C);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_load();
                t_gate();
                t_cont_square();
                t_pulse();
                t_freeze();
                t_retrig();
                t_disable();
                t_ext();
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule